// File: doc/BRIEF.md
# 64-bit Interval Timer

A memory-mapped interval timer with a 64-bit up-counter, controlled over a simple 32-bit register bus. A register access is a single bus-clock cycle: address, write enable and write data for writes, and address plus read enable for reads. Read data is valid combinationally in the same cycle. Any side effect of a read, such as a snapshot or a status clear, takes place at the clock edge that ends the access.

The count source is chosen at start time. It is either every bus-clock cycle or each rising edge of a slower generic tick input. The generic tick input must toggle at no more than one third of the bus clock rate. It passes through a two-flop synchroniser and an edge detector. The chosen source is divided by a 4-bit prescaler, giving a division of p+1.

In continuous mode the counter wraps after each period. In one-shot mode it stops at the period value. Each completed period sets a status flag. The flag drives a level interrupt when it is enabled.

Because the bus is 32 bits wide, a 64-bit value is read in two accesses. Reading the low word latches the matching high word, so the two accesses always yield one coherent sample. Software sets the timer up with the following sequence:
1. software reset
2. write mode
3. write period high word
4. write period low word
5. write interrupt enable
6. start

Top module: `interval_timer64`

## Requirements
- R1: After reset, every readable register reads 0 and `irq_o` is low.
- R2: Word offsets are: control 0x00 (write only, reads 0), mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, counter low 0x20, counter high 0x24. Mode keeps only bit 0 (continuous), bit 3 (generic source) and bits 11:8 (prescaler), so writing all ones reads back 0x0000_0F09. Interrupt enable keeps only bit 0.
- R3: Writing control bit 0 loads the active configuration, clears the counter and the prescaler, and starts counting up by one on each prescaled tick.
- R4: In continuous mode (mode bit 0 = 1), a prescaled tick that finds the counter equal to the period sets status bit 0 and returns the counter to 0, so one period spans period+1 ticks.
- R5: In one-shot mode (mode bit 0 = 0), the same tick sets status bit 0, and the counter then holds at the period value until the next start.
- R6: With prescaler value p in mode bits 11:8 and the bus-clock source, the counter advances once every p+1 bus cycles.
- R7: With mode bit 3 set, only synchronised rising edges of `gtick_i` are counted, and bus-clock cycles are not.
- R8: A read of the counter low word captures the counter high word in the same cycle. Later reads of the high word return that captured value until the next low-word read.
- R9: Reading status returns the flag and clears it. If a period completes in the same cycle as the read, the flag is left set.
- R10: `irq_o` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R11: Writing control bit 8 stops the timer and clears the counter, the prescaler and the status flag. It wins over bit 0 written in the same access.
- R12: Mode and period writes made while the timer runs or is stopped do not take effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gtick_i | input | 1 | Generic tick input, asynchronous, at most one third of the bus clock rate |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe for one cycle |
| rd_data_o | output | 32 | Read data, valid in the cycle of `rd_en_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land on the same edge.

The first pair is a period completion and a status read. The bench starts a period-20 continuous count, then waits until the status read falls on exactly the edge where the counter meets the period. That read must return 0, because the flag is not yet set. The following read must return 1, because the set wins over the clear. A third read must return 0.

The second pair is a low-word snapshot and a carry into the high word. A second instance splits the counter at bit 4 so that a carry is reachable. A low read taken just before the carry, followed ten cycles later by a high read, must return the pre-carry high value.

// File: rtl/interval_timer64.sv
module interval_timer64 #(
  parameter int ADDR_W      = 6,
  parameter int CNT_SPLIT   = 32,
  parameter int PRES_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gtick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);

  localparam int CNT_W = 64;
  localparam int HI_W  = CNT_W - CNT_SPLIT;
  localparam int IDX_W = ADDR_W - 2;

  localparam logic [IDX_W-1:0] A_CTRL = IDX_W'(0);
  localparam logic [IDX_W-1:0] A_MODE = IDX_W'(1);
  localparam logic [IDX_W-1:0] A_PLO  = IDX_W'(2);
  localparam logic [IDX_W-1:0] A_PHI  = IDX_W'(3);
  localparam logic [IDX_W-1:0] A_IEN  = IDX_W'(4);
  localparam logic [IDX_W-1:0] A_STAT = IDX_W'(7);
  localparam logic [IDX_W-1:0] A_CLO  = IDX_W'(8);
  localparam logic [IDX_W-1:0] A_CHI  = IDX_W'(9);

  logic [IDX_W-1:0] widx;
  logic             unused_addr_bits;
  assign widx             = addr_i[ADDR_W-1:2];
  assign unused_addr_bits = &addr_i[1:0];

  // programmed configuration
  logic              mode_cont_q, mode_gsrc_q;
  logic [PRES_W-1:0] mode_pres_q;
  logic [CNT_W-1:0]  period_q;
  logic              ien_q;

  // configuration captured at start
  logic              act_cont_q, act_gsrc_q;
  logic [PRES_W-1:0] act_pres_q;
  logic [CNT_W-1:0]  act_period_q;

  logic              run_q, status_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PRES_W-1:0] pcnt_q;
  logic [HI_W-1:0]   hi_snap_q;
  logic [SYNC_STAGES:0] sync_q;

  logic wr_ctrl, swrst, start, rd_stat, rd_clo;
  logic g_rise, src_tick, pres_done, cnt_tick, hit;

  assign wr_ctrl   = wr_en_i && widx == A_CTRL;
  assign swrst     = wr_ctrl && wr_data_i[8];
  assign start     = wr_ctrl && wr_data_i[0] && !swrst;
  assign rd_stat   = rd_en_i && widx == A_STAT;
  assign rd_clo    = rd_en_i && widx == A_CLO;

  assign g_rise    = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign src_tick  = act_gsrc_q ? g_rise : 1'b1;
  assign pres_done = pcnt_q == act_pres_q;
  assign cnt_tick  = run_q && src_tick && pres_done;
  assign hit       = cnt_tick && cnt_q == act_period_q;

  assign irq_o     = status_q & ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], gtick_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_cont_q <= 1'b0;
      mode_gsrc_q <= 1'b0;
      mode_pres_q <= '0;
      period_q    <= '0;
      ien_q       <= 1'b0;
    end else if (wr_en_i) begin
      case (widx)
        A_MODE: begin
          mode_cont_q <= wr_data_i[0];
          mode_gsrc_q <= wr_data_i[3];
          mode_pres_q <= wr_data_i[8 +: PRES_W];
        end
        A_PLO:   period_q[31:0]  <= wr_data_i;
        A_PHI:   period_q[63:32] <= wr_data_i;
        A_IEN:   ien_q           <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      cnt_q        <= '0;
      pcnt_q       <= '0;
      act_cont_q   <= 1'b0;
      act_gsrc_q   <= 1'b0;
      act_pres_q   <= '0;
      act_period_q <= '0;
    end else if (swrst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else if (start) begin
      run_q        <= 1'b1;
      cnt_q        <= '0;
      pcnt_q       <= '0;
      act_cont_q   <= mode_cont_q;
      act_gsrc_q   <= mode_gsrc_q;
      act_pres_q   <= mode_pres_q;
      act_period_q <= period_q;
    end else if (run_q && src_tick) begin
      pcnt_q <= pres_done ? '0 : pcnt_q + 1'b1;
      if (hit) begin
        if (act_cont_q) cnt_q <= '0;
        else            run_q <= 1'b0;
      end else if (pres_done) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_q <= 1'b0;
    else if (swrst)   status_q <= 1'b0;
    else if (hit)     status_q <= 1'b1;
    else if (rd_stat) status_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_snap_q <= '0;
    else if (swrst)  hi_snap_q <= '0;
    else if (rd_clo) hi_snap_q <= cnt_q[CNT_W-1:CNT_SPLIT];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      case (widx)
        A_MODE: rd_data_o = {20'b0, mode_pres_q, 4'b0, mode_gsrc_q, 2'b0, mode_cont_q};
        A_PLO:  rd_data_o = period_q[31:0];
        A_PHI:  rd_data_o = period_q[63:32];
        A_IEN:  rd_data_o = {31'b0, ien_q};
        A_STAT: rd_data_o = {31'b0, status_q};
        A_CLO:  rd_data_o = 32'(cnt_q[CNT_SPLIT-1:0]);
        A_CHI:  rd_data_o = 32'(hi_snap_q);
        default: rd_data_o = '0;
      endcase
    end
  end

  assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= act_period_q);

  assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start && !swrst) |=> $stable(cnt_q));

  assert_pres_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= act_pres_q);

  assert_snapshot_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_clo && !swrst) |=> $stable(hi_snap_q));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !hit) |=> !status_q);

  assert_swrst_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    swrst |=> (!run_q && cnt_q == '0 && !status_q && !irq_o));

endmodule

// File: tb/interval_timer64_test.sv
`timescale 1ns/1ps
module interval_timer64_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gtick = 1'b0;
  logic [5:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b, rdata;
  logic irq_a, irq_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  interval_timer64 uut (
    .clk(clk), .rst_n(rst_n), .gtick_i(gtick), .addr_i(addr),
    .wr_en_i(wr_en && !sel), .wr_data_i(wdata), .rd_en_i(rd_en && !sel),
    .rd_data_o(rdata_a), .irq_o(irq_a));

  interval_timer64 #(.CNT_SPLIT(4)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .gtick_i(gtick), .addr_i(addr),
    .wr_en_i(wr_en && sel), .wr_data_i(wdata), .rd_en_i(rd_en && sel),
    .rd_data_o(rdata_b), .irq_o(irq_b));

  assign rdata = sel ? rdata_b : rdata_a;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [31:0] mode, logic [31:0] phi, logic [31:0] plo, logic [31:0] ien);
    wr(6'h00, 32'h100); wr(6'h04, mode); wr(6'h0C, phi);
    wr(6'h08, plo); wr(6'h10, ien); wr(6'h00, 32'h1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h04, v); chk("R1 mode", v, 0);
    rd(6'h08, v); chk("R1 period lo", v, 0);
    rd(6'h0C, v); chk("R1 period hi", v, 0);
    rd(6'h10, v); chk("R1 ien", v, 0);
    rd(6'h1C, v); chk("R1 status", v, 0);
    rd(6'h20, v); chk("R1 count lo", v, 0);
    rd(6'h24, v); chk("R1 count hi", v, 0);
    chk("R1 irq", 32'(irq_a), 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); chk("R2 mode mask", v, 32'h0000_0F09);
    wr(6'h08, 32'h1234_5678); rd(6'h08, v); chk("R2 period lo", v, 32'h1234_5678);
    wr(6'h0C, 32'h9ABC_DEF0); rd(6'h0C, v); chk("R2 period hi", v, 32'h9ABC_DEF0);
    wr(6'h10, 32'hFFFF_FFFF); rd(6'h10, v); chk("R2 ien mask", v, 1);
    rd(6'h00, v); chk("R2 control reads 0", v, 0);
    wr(6'h10, 0); wr(6'h04, 0);
  endtask

  task automatic t_continuous;
    logic [31:0] v;
    cfg(32'h1, 0, 4, 0);
    idle(2);    rd(6'h20, v); chk("R3 counts up", v, 2);
    idle(1);    rd(6'h20, v); chk("R4 reaches period", v, 4);
    rd(6'h1C, v); chk("R4 status set", v, 1);
    rd(6'h20, v); chk("R4 wrapped", v, 1);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    cfg(32'h0, 0, 3, 1);
    idle(10);   rd(6'h20, v); chk("R5 holds at period", v, 3);
    chk("R10 irq on", 32'(irq_a), 1);
    wr(6'h10, 0); chk("R10 irq masked", 32'(irq_a), 0);
    wr(6'h10, 1); chk("R10 irq unmasked", 32'(irq_a), 1);
    rd(6'h1C, v); chk("R9 status read", v, 1);
    chk("R10 irq after clear", 32'(irq_a), 0);
    rd(6'h1C, v); chk("R9 status cleared", v, 0);
    wr(6'h04, 32'h1); wr(6'h08, 1);
    idle(5); rd(6'h20, v); chk("R12 no restart", v, 3);
    wr(6'h00, 32'h1);
    idle(2); rd(6'h20, v); chk("R12 new period at start", v, 0);
    rd(6'h1C, v); chk("R12 new period flag", v, 1);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    cfg(32'h201, 0, 1000, 0);
    idle(8); rd(6'h20, v); chk("R6 div3 early", v, 2);
    rd(6'h20, v); chk("R6 div3 step", v, 3);
  endtask

  task automatic t_period_write;
    logic [31:0] v;
    cfg(32'h1, 0, 50, 0);
    wr(6'h08, 2);
    idle(9); rd(6'h20, v); chk("R12 period write deferred", v, 10);
    rd(6'h1C, v); chk("R12 no early flag", v, 0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    cfg(32'h1, 0, 20, 0);
    idle(20);
    rd(6'h1C, v); chk("R9 read on hit edge", v, 0);
    rd(6'h1C, v); chk("R9 set wins", v, 1);
    rd(6'h1C, v); chk("R9 then clears", v, 0);
  endtask

  task automatic t_swrst;
    logic [31:0] v;
    cfg(32'h0, 0, 3, 1);
    idle(10);
    wr(6'h00, 32'h101);
    chk("R11 irq low", 32'(irq_a), 0);
    rd(6'h20, v); chk("R11 count cleared", v, 0);
    idle(5); rd(6'h20, v); chk("R11 start ignored", v, 0);
    rd(6'h1C, v); chk("R11 status cleared", v, 0);
    cfg(32'h1, 0, 100, 0);
    idle(5); wr(6'h00, 32'h100);
    idle(3); rd(6'h20, v); chk("R11 stops running", v, 0);
  endtask

  task automatic t_gclk;
    logic [31:0] v;
    cfg(32'h9, 0, 1000, 0);
    idle(4);
    for (int i = 0; i < 5; i++) begin
      gtick = 1'b1; idle(4);
      gtick = 1'b0; idle(4);
    end
    idle(6);
    rd(6'h20, v); chk("R7 generic edges counted", v, 5);
  endtask

  task automatic t_atomic;
    logic [31:0] v;
    sel = 1'b1;
    cfg(32'h1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    idle(15); rd(6'h20, v); chk("R8 low before carry", v, 15);
    idle(10); rd(6'h24, v); chk("R8 high is snapshot", v, 0);
    rd(6'h20, v); chk("R8 low after carry", v, 11);
    rd(6'h24, v); chk("R8 new snapshot", v, 1);
    sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_continuous();
    t_oneshot();
    t_prescale();
    t_period_write();
    t_collision();
    t_swrst();
    t_gclk();
    t_atomic();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule